// File: doc/BRIEF.md
# Reverse-Subtract Skip-On-Borrow Processor

This block is a tiny accumulator machine that executes exactly one kind of instruction, so an instruction word carries no opcode: it is simply the address of one memory operand. Executing it subtracts the accumulator from that memory word, and the difference lands both in the accumulator and back in the same memory word. A signed borrow makes the core skip the following instruction. The program counter and the accumulator are aliased into the low end of the address space. Any flow of control beyond the skip is therefore done by writing the program-counter location.

A host fills the 256-word memory through a simple write/read port while the core is stopped. It then pulses `start` and waits for `halted`. The core halts when the program counter points outside the memory. Results are read back through the same port, which also exposes the program counter (address 0) and the accumulator (address 1).

Top module: `rssb_core`

## Requirements
- R1: After reset the program counter holds 2, the accumulator holds 0, `halted` is 0, and a host read of address 0 returns 2 and of address 1 returns 0.
- R2: While the core is stopped (after reset or while halted), a host write stores `hostWdata`; address 0 loads the program counter, address 1 loads the accumulator, and any other address loads that memory word. A host read returns the same view combinationally. Host writes made while the core is running have no effect.
- R3: Nothing executes until `start` is pulsed. A start pulse while stopped begins execution at the current program counter.
- R4: An instruction's operand address is the low 8 bits of the word at the program counter. The core forms operand minus accumulator in 16-bit wrapping arithmetic and writes it to the accumulator and to the operand word.
- R5: Without a borrow the program counter advances by 1.
- R6: A borrow occurs when the operand is smaller than the accumulator under signed 16-bit comparison. The program counter then advances by 2, and the skipped instruction changes no memory word.
- R7: Operand address 0 reads the current program counter. The result is written to the program counter in place of the increment or skip, and it is also written to the accumulator.
- R8: Operand address 1 uses the accumulator as the operand, so the accumulator becomes 0 with no borrow and the program counter advances by 1.
- R9: When a fetch finds the program counter at 256 or above (unsigned), the core stops and holds `halted` high, changing no state, until the next start pulse.
- R10: Every instruction takes exactly two clocks, one to fetch and one to execute, and the core never executes on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock pulse that begins execution |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host address (0 = program counter, 1 = accumulator) |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data for `hostAddr` |
| halted | output | 1 | High once the program counter has left the memory |

## Verification
The assertions check every executed instruction as it happens. They confirm the accumulator result, the step by 1 or 2 chosen by the borrow, the redirect through address 0, the zeroing through address 1, the spacing of execute cycles and that `halted` holds. The effect of a skip on memory, and the fact that host writes are ignored during a run, can only be seen through the bench scenarios. Those scenarios read the words back after halt: a full difference routine whose skipped slots point at canary words, a run off the top of memory, and a signed-overflow borrow. A behavioural model in the bench follows the core every clock.

// File: rtl/rssb_pkg.sv
package rssb_pkg;
  localparam int DataW   = 16;
  localparam int Depth   = 256;
  localparam int StartPc = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_HALT  = 2'd3
  } state_t;

  typedef struct packed {
    logic fetchEn;
    logic execEn;
    logic hostWrEn;
  } ctl_t;
endpackage

// File: rtl/rssb_ctrl.sv
module rssb_ctrl
  import rssb_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic hostWe,
  input  logic pcOut,
  output ctl_t ctl,
  output logic halted
);
  state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE, ST_HALT: if (start) stateNext = ST_FETCH;
      ST_FETCH:         stateNext = pcOut ? ST_HALT : ST_EXEC;
      ST_EXEC:          stateNext = ST_FETCH;
      default:          stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.fetchEn  = (state == ST_FETCH) && !pcOut;
    ctl.execEn   = (state == ST_EXEC);
    ctl.hostWrEn = hostWe && ((state == ST_IDLE) || (state == ST_HALT));
  end

  assign halted = (state == ST_HALT);
endmodule

// File: rtl/rssb_dpath.sv
module rssb_dpath
  import rssb_pkg::*;
#(
  parameter int DATA_W   = DataW,
  parameter int DEPTH    = Depth,
  parameter int START_PC = StartPc,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              pcOut,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] pcVal,
  output logic [DATA_W-1:0] accVal,
  output logic [DATA_W-1:0] rdVal,
  output logic              borrow
);
  localparam logic [ADDR_W-1:0] PcLoc  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AccLoc = ADDR_W'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pc, acc, result, instrWord;
  logic [ADDR_W-1:0] opReg;
  logic              unusedHigh;

  assign instrWord  = mem[pc[ADDR_W-1:0]];
  assign unusedHigh = ^instrWord[DATA_W-1:ADDR_W];
  assign pcOut      = pc >= DATA_W'(DEPTH);

  // operand select: the two aliased locations shadow the array
  always_comb begin
    if (opReg == PcLoc)       rdVal = pc;
    else if (opReg == AccLoc) rdVal = acc;
    else                      rdVal = mem[opReg];
  end

  assign result = rdVal - acc;
  assign borrow = $signed(rdVal) < $signed(acc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= DATA_W'(START_PC);
      acc   <= '0;
      opReg <= '0;
    end else begin
      if (ctl.fetchEn) opReg <= instrWord[ADDR_W-1:0];
      if (ctl.hostWrEn && hostAddr == PcLoc)       pc <= hostWdata;
      else if (ctl.execEn) begin
        if (opReg == PcLoc) pc <= result;
        else if (borrow)    pc <= pc + DATA_W'(2);
        else                pc <= pc + DATA_W'(1);
      end
      if (ctl.hostWrEn && hostAddr == AccLoc) acc <= hostWdata;
      else if (ctl.execEn)                    acc <= result;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.hostWrEn && hostAddr > AccLoc)  mem[hostAddr] <= hostWdata;
    else if (ctl.execEn && opReg > AccLoc)  mem[opReg]    <= result;
  end

  always_comb begin
    if (hostAddr == PcLoc)       hostRdata = pc;
    else if (hostAddr == AccLoc) hostRdata = acc;
    else                         hostRdata = mem[hostAddr];
  end

  assign opAddr = opReg;
  assign pcVal  = pc;
  assign accVal = acc;
endmodule

// File: rtl/rssb_core.sv
module rssb_core
  import rssb_pkg::*;
#(
  parameter int DATA_W   = DataW,
  parameter int DEPTH    = Depth,
  parameter int START_PC = StartPc,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              halted
);
  ctl_t              ctl;
  logic              pcOut, borrow;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] pcVal, accVal, rdVal;

  rssb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .hostWe(hostWe),
    .pcOut(pcOut), .ctl(ctl), .halted(halted)
  );

  rssb_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .START_PC(START_PC)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .pcOut(pcOut),
    .opAddr(opAddr), .pcVal(pcVal), .accVal(accVal), .rdVal(rdVal),
    .borrow(borrow)
  );
endmodule

// File: rtl/rssb_core_chk.sv
module rssb_core_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              halted,
  input logic              execEn,
  input logic [ADDR_W-1:0] opAddr,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] rdVal,
  input logic              borrow
);
  a_r4_acc_result: assert property (@(posedge clk) disable iff (!rstN)
    execEn && opAddr > ADDR_W'(1) |=> acc == DATA_W'($past(rdVal) - $past(acc)));

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rstN)
    execEn && opAddr > ADDR_W'(1) && !borrow |=> pc == DATA_W'($past(pc) + DATA_W'(1)));

  a_r6_skip_two: assert property (@(posedge clk) disable iff (!rstN)
    execEn && opAddr > ADDR_W'(1) && borrow |=> pc == DATA_W'($past(pc) + DATA_W'(2)));

  a_r7_pc_redirect: assert property (@(posedge clk) disable iff (!rstN)
    execEn && opAddr == ADDR_W'(0) |=> pc == DATA_W'($past(pc) - $past(acc)));

  a_r8_acc_clear: assert property (@(posedge clk) disable iff (!rstN)
    execEn && opAddr == ADDR_W'(1) |=> acc == '0 && pc == DATA_W'($past(pc) + DATA_W'(1)));

  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rstN)
    halted && !start |=> halted);

  a_r10_exec_spaced: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> !execEn);
endmodule

bind rssb_core rssb_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .halted(halted),
  .execEn(ctl.execEn), .opAddr(opAddr), .pc(pcVal), .acc(accVal),
  .rdVal(rdVal), .borrow(borrow)
);

// File: tb/rssb_core_tb_top.sv
module rssb_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        hostWe = 1'b0;
  logic [7:0]  hostAddr = 8'd1;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        halted;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  always #5 clk = ~clk;

  rssb_core dut_i (
    .clk(clk), .rstN(rstN), .start(start), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .halted(halted)
  );

  // behavioural reference: phase 0 idle, 1 fetch, 2 execute, 3 halted
  logic [15:0] mMem [256];
  logic [15:0] mPc, mAcc, mVal, mRes, mRead;
  logic [7:0]  mOp;
  int          mPhase;
  logic        mBorrow;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPc = 16'd2; mAcc = '0; mPhase = 0; mOp = '0;
    end else begin
      case (mPhase)
        0, 3: begin
          if (hostWe) begin
            if (hostAddr == 0)      mPc = hostWdata;
            else if (hostAddr == 1) mAcc = hostWdata;
            else                    mMem[hostAddr] = hostWdata;
          end
          if (start) mPhase = 1;
        end
        1: begin
          if (mPc >= 16'd256) mPhase = 3;
          else begin mOp = mMem[mPc[7:0]][7:0]; mPhase = 2; end
        end
        default: begin
          mVal = (mOp == 0) ? mPc : (mOp == 1) ? mAcc : mMem[mOp];
          mRes = mVal - mAcc;
          mBorrow = $signed(mVal) < $signed(mAcc);
          mAcc = mRes;
          if (mOp == 0) mPc = mRes;
          else          mPc = mPc + (mBorrow ? 16'd2 : 16'd1);
          if (mOp > 1) mMem[mOp] = mRes;
          mPhase = 1;
        end
      endcase
    end
    #2;
    if (rstN) begin
      mRead = (hostAddr == 0) ? mPc : (hostAddr == 1) ? mAcc : mMem[hostAddr];
      check("R10 halted per clock", {15'd0, halted}, {15'd0, mPhase == 3});
      check("R10 read port per clock", hostRdata, mRead);
    end
  end

  task automatic hostWrite(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWe = 1'b1;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(string tag, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    hostAddr = a;
    #1;
    check(tag, hostRdata, exp);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitHalt(string tag);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    check(tag, {15'd0, halted}, 16'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R1 halted after reset", {15'd0, halted}, 16'd0);
    hostRead("R1 pc after reset", 8'd0, 16'd2);
    hostRead("R1 acc after reset", 8'd1, 16'd0);
    for (int a = 2; a < 256; a++) hostWrite(8'(a), 16'd0);
    hostRead("R3 no run before start", 8'd0, 16'd2);

    // difference routine: x(101) = y(102) - z(103), temp 100, canary 104
    hostWrite(8'd100, 16'd5);   hostWrite(8'd101, 16'd9);
    hostWrite(8'd102, 16'd100); hostWrite(8'd103, 16'd30);
    hostWrite(8'd104, 16'd1234);
    hostWrite(8'd2, 16'd100);  hostWrite(8'd3, 16'd100);  hostWrite(8'd4, 16'd100);
    hostWrite(8'd5, 16'd101);  hostWrite(8'd6, 16'd101);  hostWrite(8'd7, 16'd102);
    hostWrite(8'd8, 16'd100);  hostWrite(8'd9, 16'd104);  hostWrite(8'd10, 16'd101);
    hostWrite(8'd11, 16'd100); hostWrite(8'd12, 16'd104); hostWrite(8'd13, 16'd100);
    hostWrite(8'd14, 16'd103); hostWrite(8'd15, 16'd101); hostWrite(8'd16, 16'd0);
    pulseStart();
    waitHalt("R9 routine halts");
    hostRead("R4 x = y - z", 8'd101, 16'd70);
    hostRead("R6 skipped slots left canary", 8'd104, 16'd1234);
    hostRead("R5 temp cleared", 8'd100, 16'd0);
    hostRead("R4 y unchanged", 8'd102, 16'd100);
    hostRead("R7 pc redirected", 8'd0, 16'hFFCA);
    hostRead("R7 acc gets redirect value", 8'd1, 16'hFFCA);

    // top-of-memory run with accumulator operand and a skip
    hostWrite(8'd110, 16'd5); hostWrite(8'd111, 16'd2);
    hostWrite(8'd112, 16'd77); hostWrite(8'd113, 16'd0);
    hostWrite(8'd250, 16'd1);  hostWrite(8'd251, 16'd110); hostWrite(8'd252, 16'd111);
    hostWrite(8'd253, 16'd112); hostWrite(8'd254, 16'd1);  hostWrite(8'd255, 16'd113);
    hostWrite(8'd0, 16'd250);  hostWrite(8'd1, 16'd3);
    hostRead("R2 pc loaded by host", 8'd0, 16'd250);
    hostRead("R2 acc loaded by host", 8'd1, 16'd3);
    pulseStart();
    waitHalt("R9 run off top halts");
    hostRead("R8 acc operand cleared acc", 8'd110, 16'd5);
    hostRead("R6 borrow result stored", 8'd111, 16'hFFFD);
    hostRead("R6 skipped word intact", 8'd112, 16'd77);
    hostRead("R9 pc past memory", 8'd0, 16'd256);
    hostRead("R8 final acc", 8'd1, 16'd0);

    // host writes during a run are ignored
    for (int a = 200; a < 256; a++) hostWrite(8'(a), 16'd1);
    hostWrite(8'd120, 16'd11);
    hostWrite(8'd0, 16'd200);
    pulseStart();
    repeat (6) @(negedge clk);
    hostWrite(8'd120, 16'd999);
    hostWrite(8'd0, 16'd5);
    waitHalt("R9 long run halts");
    hostRead("R2 write during run ignored", 8'd120, 16'd11);
    hostRead("R2 pc write during run ignored", 8'd0, 16'd256);

    // signed borrow where the wrapped difference is positive
    hostWrite(8'd114, 16'h8000); hostWrite(8'd115, 16'd55);
    hostWrite(8'd240, 16'd114);  hostWrite(8'd241, 16'd115);
    hostWrite(8'd0, 16'd240);    hostWrite(8'd1, 16'd1);
    pulseStart();
    waitHalt("R9 signed run halts");
    hostRead("R4 wrapped result", 8'd114, 16'h7FFF);
    hostRead("R6 signed borrow skipped", 8'd115, 16'd55);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule